// File: doc/BRIEF.md
# Host/Guest Speculation-Control Register Pair

This block holds a speculation-control register twice: one copy for the host and one for the guest. It also tracks whether the core is in host mode or in guest mode. It drives an effective control word to the core's speculation logic. In host mode that word is the host copy alone. In guest mode it is the host copy ORed with the guest copy, so the host can enforce a minimum set of controls. For guests flagged as secure, the word is the guest copy alone.

Software reads and writes the register through a single port. Each access reaches the copy that belongs to the current mode. A guest-entry strobe makes the block read the guest copy from the guest's control block in memory. A guest-exit strobe makes it write the guest copy back. Each strobe is acknowledged by a one-cycle done pulse once the memory transfer has completed. The slot inside the control block sits at the save-area base (0x400) plus 0x2E0, which is byte offset 0x6E0 from the control-block base.

Top module: `spc_pair`

## Requirements
- R1: After reset both copies are zero. The block is in host mode (`guest_mode`=0), `eff_ctrl` is zero, and `mem_valid` is low.
- R2: In host mode a register write changes only the host copy. Both `reg_rd_data` and `eff_ctrl` then equal the host copy.
- R3: An accepted entry request issues one memory read (`mem_write`=0) at `entry_base` + 0x6E0. The returned `mem_rdata` becomes the guest copy.
- R4: `guest_mode` changes only after the memory handshake (`mem_valid` and `mem_ready` high at one clock edge). In the cycle after that edge, the new mode and a one-cycle `entry_done` or `exit_done` pulse appear together.
- R5: In guest mode a register write changes only the guest copy, and `reg_rd_data` returns the guest copy. The host copy is untouched, which shows on `reg_rd_data` after exit.
- R6: In guest mode with the secure flag clear, `eff_ctrl` is the bitwise OR of the host and guest copies.
- R7: `entry_secure` is sampled when the entry request is accepted. When it is set, `eff_ctrl` in guest mode equals the guest copy alone.
- R8: An accepted exit request issues one memory write (`mem_write`=1) of the guest copy at the same address. The block then returns to host mode, where `eff_ctrl` and `reg_rd_data` equal the host copy.
- R9: Requests that cannot be accepted are ignored and raise `seq_err` for one cycle without changing the mode or either copy. These are an entry request outside host mode and an exit request outside guest mode, including during a transfer.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_data | output | DATA_W | Copy belonging to the current mode |
| entry_req | input | 1 | Guest-entry request strobe |
| entry_base | input | ADDR_W | Control-block base address for the entry |
| entry_secure | input | 1 | Guest is secure: guest copy alone drives the output |
| exit_req | input | 1 | Guest-exit request strobe |
| entry_done | output | 1 | One-cycle entry acknowledge |
| exit_done | output | 1 | One-cycle exit acknowledge |
| seq_err | output | 1 | One-cycle pulse for a rejected request |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Store data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | DATA_W | Load data, valid with mem_ready |
| guest_mode | output | 1 | 1 = guest mode |
| eff_ctrl | output | DATA_W | Effective speculation-control word |

## Verification
The checker watches several relations on every cycle:
- the reset state;
- that the mode flips only together with the matching done pulse;
- that the memory request stays stable while stalled;
- that loads happen only in host mode and stores only in guest mode;
- that in host mode the effective word equals the readable copy;
- that in guest mode the effective word always contains every bit of the guest copy.

The bench scenarios are needed for the rest:
- the exact request address;
- the loaded and stored values, including a store-then-reload round trip;
- OR versus secure selection;
- the host copy surviving guest writes;
- rejected requests leaving the state untouched.

// File: rtl/spc_pkg.sv
// Shared types for the speculation-control register pair.
package spc_pkg;
    // Sequencer states: two resting states and two transfer states.
    typedef enum logic [1:0] {
        ST_HOST  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_GUEST = 2'd2,
        ST_STORE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/spc_copies.sv
// Holds the host and guest register copies.
// Assumes: guest_sel selects which copy a software write reaches; load_en
// (a memory fill of the guest copy) only occurs while guest_sel is low.
module spc_copies #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              guest_sel,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] host_q,
    output logic [DATA_W-1:0] guest_q
);
    // Host copy: updated only by host-mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_q <= '0;
        else if (wr_en && !guest_sel)
            host_q <= wr_data;
    end

    // Guest copy: filled from memory on entry, else by guest-mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            guest_q <= '0;
        else if (load_en)
            guest_q <= load_data;
        else if (wr_en && guest_sel)
            guest_q <= wr_data;
    end
endmodule

// File: rtl/spc_sequencer.sv
// Entry/exit sequencer: accepts mode-change requests, runs the single
// load or store on the memory port, and acknowledges on completion.
// Assumes: mem_rdata is valid in the cycle mem_ready is high for a load;
// request strobes may arrive in any state.
module spc_sequencer
    import spc_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 48,
    parameter int GUEST_OFS = 'h6E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_req,
    input  logic [ADDR_W-1:0] entry_base,
    input  logic              entry_secure,
    input  logic              exit_req,
    input  logic [DATA_W-1:0] guest_copy,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              load_en,
    output logic              guest_mode,
    output logic              secure_q,
    output logic              entry_done,
    output logic              exit_done,
    output logic              seq_err
);
    localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(GUEST_OFS);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] snap_q;
    logic              fire;
    logic              entry_ok, exit_ok, reject;

    assign fire     = mem_valid && mem_ready;
    assign entry_ok = entry_req && (state_q == ST_HOST);
    assign exit_ok  = exit_req  && (state_q == ST_GUEST);
    assign reject   = (entry_req && (state_q != ST_HOST)) ||
                      (exit_req  && (state_q != ST_GUEST));

    // Next-state selection for the entry/exit sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOST:  if (entry_ok) state_d = ST_LOAD;
            ST_LOAD:  if (fire)     state_d = ST_GUEST;
            ST_GUEST: if (exit_ok)  state_d = ST_STORE;
            ST_STORE: if (fire)     state_d = ST_HOST;
            default:                state_d = ST_HOST;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOST;
        else        state_q <= state_d;
    end

    // Capture the control-block base and secure flag when an entry is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            secure_q <= 1'b0;
        end else if (entry_ok) begin
            base_q   <= entry_base;
            secure_q <= entry_secure;
        end
    end

    // Snapshot the guest copy at exit acceptance so store data stays stable.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (exit_ok) snap_q <= guest_copy;
    end

    // One-cycle acknowledge and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_done <= 1'b0;
            exit_done  <= 1'b0;
            seq_err    <= 1'b0;
        end else begin
            entry_done <= fire && (state_q == ST_LOAD);
            exit_done  <= fire && (state_q == ST_STORE);
            seq_err    <= reject;
        end
    end

    assign mem_valid  = (state_q == ST_LOAD) || (state_q == ST_STORE);
    assign mem_write  = (state_q == ST_STORE);
    assign mem_addr   = base_q + SLOT_OFS;
    assign mem_wdata  = snap_q;
    assign load_en    = fire && (state_q == ST_LOAD);
    assign guest_mode = (state_q == ST_GUEST) || (state_q == ST_STORE);
endmodule

// File: rtl/spc_effective.sv
// Forms the effective control word and the software-readable value.
// Assumes: copies and mode come straight from registers.
// OR_ENABLE = 0 builds a variant in which guest mode always uses the guest
// copy alone.
module spc_effective #(
    parameter int DATA_W    = 64,
    parameter bit OR_ENABLE = 1'b1
) (
    input  logic              guest_mode,
    input  logic              secure,
    input  logic [DATA_W-1:0] host_q,
    input  logic [DATA_W-1:0] guest_q,
    output logic [DATA_W-1:0] eff_ctrl,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] guest_eff;

    generate
        if (OR_ENABLE) begin : g_or
            // Host copy sets a floor unless the guest is secure.
            assign guest_eff = secure ? guest_q : (guest_q | host_q);
        end else begin : g_plain
            assign guest_eff = guest_q;
        end
    endgenerate

    // Mode selects the effective word and the readable copy.
    always_comb begin
        eff_ctrl = guest_mode ? guest_eff : host_q;
        rd_data  = guest_mode ? guest_q   : host_q;
    end
endmodule

// File: rtl/spc_pair.sv
// Top of the host/guest speculation-control register pair.
// Assumes: one outstanding memory request at a time, valid/ready handshake,
// and the guest slot at save-area offset plus slot offset in the control block.
module spc_pair #(
    parameter int DATA_W        = 64,
    parameter int ADDR_W        = 48,
    parameter int SAVE_AREA_OFS = 'h400,
    parameter int SLOT_OFS      = 'h2E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              entry_req,
    input  logic [ADDR_W-1:0] entry_base,
    input  logic              entry_secure,
    input  logic              exit_req,
    output logic              entry_done,
    output logic              exit_done,
    output logic              seq_err,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              guest_mode,
    output logic [DATA_W-1:0] eff_ctrl
);
    localparam int GUEST_OFS = SAVE_AREA_OFS + SLOT_OFS;

    logic [DATA_W-1:0] host_q, guest_q;
    logic              load_en, secure_q;

    spc_sequencer #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GUEST_OFS(GUEST_OFS)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .entry_req(entry_req), .entry_base(entry_base),
        .entry_secure(entry_secure), .exit_req(exit_req),
        .guest_copy(guest_q), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .load_en(load_en), .guest_mode(guest_mode), .secure_q(secure_q),
        .entry_done(entry_done), .exit_done(exit_done), .seq_err(seq_err)
    );

    spc_copies #(.DATA_W(DATA_W)) i_copies (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .guest_sel(guest_mode), .load_en(load_en), .load_data(mem_rdata),
        .host_q(host_q), .guest_q(guest_q)
    );

    spc_effective #(.DATA_W(DATA_W), .OR_ENABLE(1'b1)) i_eff (
        .guest_mode(guest_mode), .secure(secure_q),
        .host_q(host_q), .guest_q(guest_q),
        .eff_ctrl(eff_ctrl), .rd_data(reg_rd_data)
    );
endmodule

// File: rtl/spc_pair_chk.sv
// Port-level checker for spc_pair, attached with bind.
module spc_pair_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic              entry_done,
    input logic              exit_done,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              guest_mode,
    input logic [DATA_W-1:0] eff_ctrl
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!guest_mode && eff_ctrl == '0 && !mem_valid));

    // R4
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guest_mode) |-> entry_done);

    // R4
    exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guest_mode) |-> exit_done);

    // R4
    entry_done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (guest_mode && !$past(guest_mode)));

    // R10
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_write) && $stable(mem_wdata)));

    // R3
    load_in_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |-> !guest_mode);

    // R8
    store_in_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> guest_mode);

    // R2
    host_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !guest_mode |-> (eff_ctrl == reg_rd_data));

    // R6
    guest_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guest_mode |-> ((eff_ctrl & reg_rd_data) == reg_rd_data));
endmodule

bind spc_pair spc_pair_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd_data(reg_rd_data),
    .entry_done(entry_done), .exit_done(exit_done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .guest_mode(guest_mode), .eff_ctrl(eff_ctrl)
);

// File: tb/test_spc_pair.sv
`timescale 1ns/1ps
// Scoreboard bench for spc_pair.
module test_spc_pair;
    localparam int DW  = 64;
    localparam int AW  = 48;
    localparam logic [AW-1:0] OFS = 48'h6E0;

    typedef struct {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } mem_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [DW-1:0] reg_rd_data;
    logic          entry_req = 1'b0;
    logic [AW-1:0] entry_base = '0;
    logic          entry_secure = 1'b0;
    logic          exit_req = 1'b0;
    logic          entry_done, exit_done, seq_err;
    logic          mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          guest_mode;
    logic [DW-1:0] eff_ctrl;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wait_cnt = 0;
    mem_item_t sb[$];
    logic [DW-1:0] mem [logic [AW-1:0]];

    always #2 clk = ~clk;

    spc_pair i_spc_pair (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .entry_req(entry_req), .entry_base(entry_base), .entry_secure(entry_secure),
        .exit_req(exit_req), .entry_done(entry_done), .exit_done(exit_done),
        .seq_err(seq_err), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .guest_mode(guest_mode), .eff_ctrl(eff_ctrl)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model and monitor: raises ready after lat cycles, compares each
    // request against the scoreboard head.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end else if (mem_valid) begin
            if (wait_cnt >= lat) begin
                mem_ready = 1'b1;
                if (sb.size() == 0) begin
                    check(1'b0, "R3/R8 unexpected request", DW'(mem_addr), '0);
                end else begin
                    mem_item_t e;
                    e = sb.pop_front();
                    check(mem_write == e.wr, "R3/R8 direction", DW'(mem_write), DW'(e.wr));
                    check(mem_addr == e.addr, "R3/R8 address", DW'(mem_addr), DW'(e.addr));
                    if (e.wr)
                        check(mem_wdata == e.data, "R8 store data", mem_wdata, e.data);
                end
                if (mem_write) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : '0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic reg_write(input logic [DW-1:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_entry(input logic [AW-1:0] base, input bit sec, input int l);
        mem_item_t e;
        e.wr = 1'b0; e.addr = base + OFS; e.data = '0;
        sb.push_back(e);
        lat = l;
        entry_req = 1'b1; entry_base = base; entry_secure = sec;
        @(negedge clk);
        entry_req = 1'b0; entry_secure = 1'b0;
        for (int i = 0; i < 40 && !entry_done; i++) begin
            // R4: mode must not switch before completion
            check(!guest_mode, "R4 early guest mode", DW'(guest_mode), '0);
            @(negedge clk);
        end
        check(entry_done && guest_mode, "R4 entry done with mode", DW'({entry_done, guest_mode}), 2'b11);
        @(negedge clk);
        check(!entry_done, "R4 entry done one cycle", DW'(entry_done), '0);
    endtask

    task automatic do_exit(input logic [DW-1:0] exp_data, input logic [AW-1:0] base,
                           input int l);
        mem_item_t e;
        e.wr = 1'b1; e.addr = base + OFS; e.data = exp_data;
        sb.push_back(e);
        lat = l;
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        for (int i = 0; i < 40 && !exit_done; i++) begin
            check(guest_mode, "R4 early host mode", DW'(guest_mode), 1);
            @(negedge clk);
        end
        check(exit_done && !guest_mode, "R8 exit done with host mode", DW'({exit_done, guest_mode}), 2'b10);
        @(negedge clk);
        check(!exit_done, "R4 exit done one cycle", DW'(exit_done), '0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        mem[48'h1000 + OFS] = 64'h00F0;
        mem[48'h2000 + OFS] = 64'h0303;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(reg_rd_data == 0 && eff_ctrl == 0, "R1 copies and output zero", eff_ctrl, '0);
        check(!guest_mode && !mem_valid, "R1 host mode idle", DW'({guest_mode, mem_valid}), '0);

        // R2
        reg_write(64'h5);
        check(reg_rd_data == 64'h5, "R2 host read", reg_rd_data, 64'h5);
        check(eff_ctrl == 64'h5, "R2 host effective", eff_ctrl, 64'h5);

        // R3, R6: entry with latency
        do_entry(48'h1000, 1'b0, 2);
        check(reg_rd_data == 64'hF0, "R3 guest copy loaded", reg_rd_data, 64'hF0);
        check(eff_ctrl == 64'hF5, "R6 OR of copies", eff_ctrl, 64'hF5);

        // R5
        reg_write(64'h0A);
        check(reg_rd_data == 64'h0A, "R5 guest write", reg_rd_data, 64'h0A);
        check(eff_ctrl == 64'h0F, "R6 OR after guest write", eff_ctrl, 64'h0F);

        // R9: entry in guest mode
        entry_req = 1'b1; entry_base = 48'h3000;
        @(negedge clk);
        entry_req = 1'b0;
        check(seq_err && !mem_valid, "R9 entry in guest rejected", DW'({seq_err, mem_valid}), 2'b10);
        @(negedge clk);
        check(!seq_err && guest_mode && reg_rd_data == 64'h0A, "R9 state unchanged", reg_rd_data, 64'h0A);

        // R8
        do_exit(64'h0A, 48'h1000, 1);
        check(reg_rd_data == 64'h5, "R5 host copy untouched", reg_rd_data, 64'h5);
        check(eff_ctrl == 64'h5, "R8 host output after exit", eff_ctrl, 64'h5);

        // R9: exit in host mode
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        check(seq_err && !mem_valid, "R9 exit in host rejected", DW'({seq_err, mem_valid}), 2'b10);
        @(negedge clk);
        check(!seq_err && !guest_mode && eff_ctrl == 64'h5, "R9 host state unchanged", eff_ctrl, 64'h5);

        // R7: secure guest
        reg_write(64'h40);
        check(eff_ctrl == 64'h40, "R2 host rewrite", eff_ctrl, 64'h40);
        do_entry(48'h2000, 1'b1, 0);
        check(eff_ctrl == 64'h0303, "R7 secure guest alone", eff_ctrl, 64'h0303);
        do_exit(64'h0303, 48'h2000, 0);
        check(eff_ctrl == 64'h40, "R8 host output", eff_ctrl, 64'h40);

        // R3/R8 round trip through the stored slot
        do_entry(48'h1000, 1'b0, 3);
        check(reg_rd_data == 64'h0A, "R3 reload stored guest", reg_rd_data, 64'h0A);
        check(eff_ctrl == 64'h4A, "R6 OR with new host", eff_ctrl, 64'h4A);
        do_exit(64'h0A, 48'h1000, 0);

        check(sb.size() == 0, "R3/R8 all requests seen", DW'(sb.size()), '0);
        finish_run();
    end
endmodule